// File: doc/BRIEF.md
# Sine Phase Generator with Pulse-Per-Second Steering

This block is the phase engine of a low-rate sine synthesizer. An 8-bit phase index selects one of 256 sine samples. A fractional accumulator advances the index by an exact rational step. With the default parameters a 10 MHz clock therefore produces exactly 60 Hz with no long-term drift. The block updates once every `CLK_DIV` clocks. On each update it presents the sample for the current phase, together with a one-cycle valid strobe, to a downstream PWM or DAC stage.

A pulse-per-second input can pull the waveform into alignment with an external time reference. The pulse is synchronized and then sampled at each update. On a rising edge, a nonzero phase is nudged one step toward index 0. Index 0 is the positive-going zero crossing. After enough pulses the zero crossing coincides with the pulse, and a lock flag reports this.

Top module: `sine_dds_pps`

## Requirements
- R1: While `rst_n` is low and after its release, the block starts with `phase_o` = 0, accumulator = 0, `sample_o` = 127, `sample_valid_o` = 0 and `lock_o` = 0. The remembered pulse level starts high, so a pulse input that is already high causes no edge.
- R2: Each update subtracts `STEP_NUM` (6144) from the accumulator.
  - If the result is negative, the block adds `STEP_DEN` (15625) and the phase advances by one, modulo 256.
  - The accumulator always stays within 0..15624.
  - With no pulse edges, the phase after N updates from reset equals ceil(N·6144/15625) mod 256.
- R3: `sample_valid_o` is a one-cycle pulse every `CLK_DIV` clocks. The first pulse comes `CLK_DIV` clocks after reset is released.
- R4: On each update, `sample_o` equals 127 + round(126·sin(2π·p/256)), where p is the phase before that update. This gives 127 at p = 0, 253 at p = 64 and 1 at p = 192.
- R5: `pps_i` passes through two flops. An edge is seen at an update when the synchronized level is high and the level seen at the previous update was low. Holding the input high gives exactly one edge.
- R6: On an edge, the block first applies that update's own advance. If the resulting phase is nonzero, it then moves one more step: +1 when phase bit 7 is set, −1 otherwise. The edge also clears `lock_o`.
- R7: On an edge where the advanced phase is 0, `lock_o` goes high. `lock_o` changes only on updates that carry an edge.
- R8: `phase_o` changes only on updates. On an update it moves by −1, 0, +1 or +2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pps_i | input | 1 | Asynchronous pulse-per-second reference |
| sample_o | output | SAMPLE_W | Sine sample for the current update |
| sample_valid_o | output | 1 | One-cycle strobe marking a new sample |
| phase_o | output | PHASE_W | Current phase index |
| lock_o | output | 1 | High once a pulse edge found the phase at zero |

## Verification
The bound checker checks several properties on every clock:
- the accumulator stays within its modulus;
- the valid strobe is a single cycle wide;
- phase and lock hold still between updates;
- each update moves the phase by a bounded amount;
- lock only rises with the phase at zero.

Other behaviour needs the bench's scenarios to show it:
- the exact rational step count over long runs and its wrap at 256;
- which sine value appears for which phase;
- the direction of each steering step;
- the edge-only response to a held-high pulse;
- the hand-derived lock and unlock sequence.

// File: rtl/sine_dds_pps.sv
module sine_dds_pps #(
  parameter int CLK_DIV  = 256,
  parameter int STEP_NUM = 6144,
  parameter int STEP_DEN = 15625,
  parameter int PHASE_W  = 8,
  parameter int SAMPLE_W = 8,
  parameter int MID      = 127,
  parameter int AMP      = 126
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                pps_i,
  output logic [SAMPLE_W-1:0] sample_o,
  output logic                sample_valid_o,
  output logic [PHASE_W-1:0]  phase_o,
  output logic                lock_o
);
  localparam int TBL_N = 1 << PHASE_W;
  localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam int ACC_W = $clog2(STEP_DEN) + 2;

  typedef logic [SAMPLE_W-1:0] tbl_t [TBL_N];

  function automatic tbl_t build_sine();
    tbl_t t;
    for (int i = 0; i < TBL_N; i++)
      t[i] = SAMPLE_W'($rtoi(real'(MID) + real'(AMP) *
             $sin(2.0 * 3.14159265358979 * real'(i) / real'(TBL_N)) + 0.5));
    return t;
  endfunction

  localparam tbl_t SINE = build_sine();

  logic [DIV_W-1:0]        div_q;
  logic [1:0]              sync_q;
  logic                    pps_prev_q;
  logic signed [ACC_W-1:0] acc_q;
  logic signed [ACC_W-1:0] acc_sub;
  logic                    tick, wrap, pps_edge, at_zero;
  logic [PHASE_W-1:0]      phase_adv, phase_nxt;

  assign tick      = (div_q == DIV_W'(CLK_DIV - 1));
  assign acc_sub   = acc_q - ACC_W'(STEP_NUM);
  assign wrap      = acc_sub[ACC_W-1];
  assign phase_adv = phase_o + PHASE_W'(wrap);
  assign pps_edge  = sync_q[1] & ~pps_prev_q;
  assign at_zero   = (phase_adv == '0);

  always_comb begin
    phase_nxt = phase_adv;
    if (pps_edge && !at_zero)
      phase_nxt = phase_adv[PHASE_W-1] ? phase_adv + 1'b1 : phase_adv - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q          <= '0;
      sync_q         <= '0;
      pps_prev_q     <= 1'b1;
      acc_q          <= '0;
      phase_o        <= '0;
      sample_o       <= SAMPLE_W'(MID);
      sample_valid_o <= 1'b0;
      lock_o         <= 1'b0;
    end else begin
      div_q          <= tick ? '0 : div_q + 1'b1;
      sync_q         <= {sync_q[0], pps_i};
      sample_valid_o <= tick;
      if (tick) begin
        sample_o   <= SINE[phase_o];
        acc_q      <= wrap ? acc_sub + ACC_W'(STEP_DEN) : acc_sub;
        phase_o    <= phase_nxt;
        pps_prev_q <= sync_q[1];
        if (pps_edge) lock_o <= at_zero;
      end
    end
  end
endmodule

// File: rtl/sine_dds_pps_chk.sv
module sine_dds_pps_chk #(
  parameter int PHASE_W  = 8,
  parameter int ACC_W    = 16,
  parameter int STEP_DEN = 15625
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    valid,
  input logic [PHASE_W-1:0]      phase,
  input logic                    lock,
  input logic signed [ACC_W-1:0] acc
);
  p_acc_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc >= 0) && (acc < ACC_W'(STEP_DEN)));

  p_valid_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> !valid);

  p_lock_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> $stable(lock));

  p_lock_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock) |-> (phase == '0));

  p_phase_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> $stable(phase));

  p_phase_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> ((PHASE_W'(phase - $past(phase)) <= PHASE_W'(2)) ||
               (PHASE_W'(phase - $past(phase)) == {PHASE_W{1'b1}})));
endmodule

bind sine_dds_pps sine_dds_pps_chk #(
  .PHASE_W(PHASE_W), .ACC_W(ACC_W), .STEP_DEN(STEP_DEN)
) u_chk (
  .clk(clk), .rst_n(rst_n), .valid(sample_valid_o),
  .phase(phase_o), .lock(lock_o), .acc(acc_q)
);

// File: tb/sine_dds_pps_tb.sv
module sine_dds_pps_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 4;
  localparam int VEC_N = 9;
  localparam int VEC [VEC_N][2] = '{
    '{1, 1}, '{2, 1}, '{3, 2}, '{10, 4}, '{100, 40},
    '{256, 101}, '{651, 0}, '{652, 1}, '{15625, 0}};

  logic clk = 1'b0, rst_n = 1'b0, pps = 1'b0;
  logic [7:0] sample_o, phase_o;
  logic sample_valid_o, lock_o;

  always #(CLK_PERIOD / 2) clk = ~clk;

  sine_dds_pps #(.CLK_DIV(DIV)) u_dut (
    .clk(clk), .rst_n(rst_n), .pps_i(pps), .sample_o(sample_o),
    .sample_valid_o(sample_valid_o), .phase_o(phase_o), .lock_o(lock_o));

  int checks = 0, errors = 0;
  int m_acc, m_phase;
  bit m_prev, m_lock, done = 0;

  function automatic int sine_ref(int p);
    return $rtoi(127.0 + 126.0 * $sin(2.0 * 3.14159265358979 * real'(p) / 256.0) + 0.5);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic do_reset(bit lvl);
    @(negedge clk);
    rst_n = 1'b0;
    pps = lvl;
    repeat (3) @(negedge clk);
    chk(phase_o == 0, "R1 reset phase", phase_o, 0);
    chk(lock_o == 0, "R1 reset lock", lock_o, 0);
    chk(sample_valid_o == 0, "R1 reset valid", sample_valid_o, 0);
    chk(sample_o == 127, "R1 reset sample", sample_o, 127);
    m_acc = 0; m_phase = 0; m_prev = 1; m_lock = 0;
    rst_n = 1'b1;
  endtask

  task automatic model_tick(bit lvl);
    int s;
    s = m_acc - 6144;
    if (s < 0) begin
      m_acc = s + 15625;
      m_phase = (m_phase + 1) % 256;
    end else m_acc = s;
    if (lvl && !m_prev) begin
      if (m_phase == 0) m_lock = 1;
      else begin
        m_phase = (m_phase >= 128) ? (m_phase + 1) % 256 : (m_phase + 255) % 256;
        m_lock = 0;
      end
    end
    m_prev = lvl;
  endtask

  task automatic step(bit lvl);
    int n, old;
    old = m_phase;
    pps = lvl;
    n = 0;
    do begin @(negedge clk); n++; end while (!sample_valid_o);
    model_tick(lvl);
    chk(n == DIV, "R3 update spacing", n, DIV);
    chk(sample_o == sine_ref(old), "R4 sample value", sample_o, sine_ref(old));
    if (old == 0)   chk(sample_o == 127, "R4 zero point", sample_o, 127);
    if (old == 64)  chk(sample_o == 253, "R4 peak", sample_o, 253);
    if (old == 192) chk(sample_o == 1, "R4 trough", sample_o, 1);
    chk(phase_o == m_phase, "R2 R6 phase", phase_o, m_phase);
    chk(lock_o == m_lock, "R7 lock", lock_o, m_lock);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    errors++;
    $display("FAIL watchdog R3: actual timeout expected completion");
    report();
  end

  initial begin
    int cur;
    do_reset(0);
    cur = 0;
    for (int v = 0; v < VEC_N; v++) begin
      while (cur < VEC[v][0]) begin step(0); cur++; end
      chk(phase_o == VEC[v][1], "R2 phase after N updates", phase_o, VEC[v][1]);
    end

    do_reset(1);
    for (int i = 0; i < 20; i++) step(1);
    chk(lock_o == 0, "R5 high from reset no edge lock", lock_o, 0);
    chk(phase_o == 8, "R5 high from reset no edge phase", phase_o, 8);

    do_reset(0);
    for (int t = 1; t <= 12; t++) begin
      step(t % 2 == 0);
      if (t == 9)  chk(lock_o == 0, "R7 not yet locked", lock_o, 0);
      if (t == 10) chk(lock_o == 1, "R7 lock at zero", lock_o, 1);
      if (t == 10) chk(phase_o == 0, "R7 phase at lock", phase_o, 0);
      if (t == 12) chk(lock_o == 0, "R6 lock cleared", lock_o, 0);
      if (t == 12) chk(phase_o == 0, "R6 step down to zero", phase_o, 0);
    end
    for (int t = 13; t <= 30; t++) step(t % 2 == 0);
    do_reset(0);
    chk(lock_o == 0, "R1 reset after lock", lock_o, 0);

    do_reset(0);
    for (int i = 0; i < 100; i++) step(0);
    step(1);
    chk(phase_o == 39, "R6 low half steps down", phase_o, 39);
    for (int i = 0; i < 50; i++) step(1);
    chk(phase_o == 59, "R5 held high single edge", phase_o, 59);

    do_reset(0);
    for (int i = 0; i < 400; i++) step(0);
    step(1);
    chk(phase_o == 159, "R6 high half steps up", phase_o, 159);
    for (int i = 0; i < 300; i++) step(i % 3 == 0);

    report();
  end
endmodule